// File: doc/BRIEF.md
# Branch Target Address Unit

This unit produces the next fetch address of a small microcontroller core. Each request carries the current 21-bit byte program counter, a 3-bit instruction class, a 20-bit absolute word-address field, an 11-bit signed word offset and a taken qualifier from the condition logic. From these it selects one of several candidates: sequential advance by 2 or 4 bytes, a long absolute jump, a short PC-relative branch, a long call or a relative call. For the two call classes it also supplies the return address that the core pushes onto its call stack.

Requests arrive on a valid/ready stream and results leave on a second valid/ready stream, with one register stage between them. A request is taken in on a clock edge where `in_valid` and `in_ready` are both high. Its result is presented on the output stream from the next cycle onward. When the consumer holds `out_ready` low while a result is waiting, the result stays frozen and `in_ready` drops, so the back-pressure reaches the producer in the same cycle. The producer must keep its request and `in_valid` steady until the request is taken in.

Top module: `next_pc_unit`

## Requirements
- R1: Class 0 (short sequential) gives next = pc + 2 and class 1 (long sequential) gives next = pc + 4, both modulo 2^21. The unused codes 6 and 7 behave as class 0.
- R2: Class 2 (long jump) gives next = the 20-bit absolute field with a zero appended below its least-significant bit, so the address is 21 bits wide and even.
- R3: Class 3 (relative branch) with the taken qualifier high gives next = pc + 2 + 2 * sign-extended 11-bit offset, modulo 2^21. An offset with bit 10 set branches backward.
- R4: Class 3 with the taken qualifier low gives next = pc + 2.
- R5: Class 4 (long call) gives the same target as R2, raises `out_push`, and gives `out_ret` = pc + 4.
- R6: Class 5 (relative call) gives the same target as a taken R3 branch, raises `out_push`, and gives `out_ret` = pc + 2. The taken qualifier has no effect on classes 0, 1, 2, 4 and 5.
- R7: Every class other than 4 and 5 leaves `out_push` low.
- R8: A relative branch or relative call whose offset is all ones (-1) targets its own address (next = pc). This is the endless self-loop.
- R9: A request accepted on an edge shows `out_valid` high after that edge. An accepted result with `out_ready` high and no new request leaves `out_valid` low after the next edge.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_pc`, `out_push` and `out_ret` hold their values.
- R11: After reset, `out_valid` and `out_push` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_pc | input | 21 | Byte address of the current instruction |
| in_kind | input | 3 | Instruction class code (0..5, 6 and 7 as 0) |
| in_taken | input | 1 | Condition met, used by class 3 only |
| in_abs | input | 20 | Absolute word-address field |
| in_off | input | 11 | Signed word offset field |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer accepts the result |
| out_pc | output | 21 | Next fetch byte address |
| out_push | output | 1 | Result belongs to a call; return address must be pushed |
| out_ret | output | 21 | Return address, meaningful when out_push is high |

## Verification
The two functions that share a cycle are redirecting the fetch to a call target and producing the return address. Both leave the block in one result, so any mix-up between the adders would corrupt one field and not the other. The bench provokes this by sweeping every 11-bit offset through relative calls and walking-bit patterns through long calls. For each result it compares `out_pc` and `out_ret` against values computed separately in the bench. A second overlap is a new request that arrives while a stalled result is still waiting. The bench judges it by checking that the old result stays frozen and that the new one appears only after `out_ready` rises.

// File: rtl/npu_pkg.sv
package npu_pkg;
  typedef enum logic [2:0] {
    K_SEQ16 = 3'd0,
    K_SEQ32 = 3'd1,
    K_JMP   = 3'd2,
    K_BR    = 3'd3,
    K_CALL  = 3'd4,
    K_RCALL = 3'd5,
    K_RSV6  = 3'd6,
    K_RSV7  = 3'd7
  } kind_e;
endpackage

// File: rtl/npu_seq.sv
// Sequential successors of the current byte address.
module npu_seq #(
  parameter int PC_W = 21
) (
  input  logic [PC_W-1:0] pc,
  output logic [PC_W-1:0] pc_p2,
  output logic [PC_W-1:0] pc_p4
);
  localparam logic [PC_W-1:0] STEP_S = PC_W'(2);
  localparam logic [PC_W-1:0] STEP_L = PC_W'(4);

  assign pc_p2 = pc + STEP_S;
  assign pc_p4 = pc + STEP_L;
endmodule

// File: rtl/npu_rel.sv
// Relative target: base (address after the instruction) plus a scaled signed word offset.
module npu_rel #(
  parameter int PC_W  = 21,
  parameter int OFF_W = 11
) (
  input  logic [PC_W-1:0]  base,
  input  logic [OFF_W-1:0] off,
  output logic [PC_W-1:0]  tgt
);
  localparam int EXT_W = PC_W - OFF_W - 1;

  logic [PC_W-1:0] disp;

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp = {{EXT_W{off[OFF_W-1]}}, off, 1'b0};
    end else begin : g_trunc
      assign disp = PC_W'({off, 1'b0});
    end
  endgenerate

  assign tgt = base + disp;
endmodule

// File: rtl/npu_abs.sv
// Absolute target: word-address field widened to a byte address.
module npu_abs #(
  parameter int PC_W  = 21,
  parameter int ABS_W = 20
) (
  input  logic [ABS_W-1:0] field,
  output logic [PC_W-1:0]  tgt
);
  localparam int PAD_W = PC_W - ABS_W - 1;

  generate
    if (PAD_W > 0) begin : g_pad
      assign tgt = {{PAD_W{1'b0}}, field, 1'b0};
    end else if (PAD_W == 0) begin : g_exact
      assign tgt = {field, 1'b0};
    end else begin : g_cut
      assign tgt = {field[PC_W-2:0], 1'b0};
    end
  endgenerate
endmodule

// File: rtl/npu_stage.sv
// One-entry valid/ready register stage carrying the result.
module npu_stage #(
  parameter int PC_W = 21
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [PC_W-1:0] in_pc,
  input  logic            in_push,
  input  logic [PC_W-1:0] in_ret,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [PC_W-1:0] out_pc,
  output logic            out_push,
  output logic [PC_W-1:0] out_ret
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pc    <= '0;
      out_push  <= 1'b0;
      out_ret   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_pc   <= in_pc;
        out_push <= in_push;
        out_ret  <= in_ret;
      end
    end
  end

  // R10: a stalled result is frozen
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pc) && $stable(out_push) && $stable(out_ret));

  // R9: accepted request appears on the next cycle
  p_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R9: consumed result with no new request empties the stage
  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);
endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
  import npu_pkg::*;
#(
  parameter int PC_W  = 21,
  parameter int ABS_W = 20,
  parameter int OFF_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PC_W-1:0]  in_pc,
  input  logic [2:0]       in_kind,
  input  logic             in_taken,
  input  logic [ABS_W-1:0] in_abs,
  input  logic [OFF_W-1:0] in_off,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PC_W-1:0]  out_pc,
  output logic             out_push,
  output logic [PC_W-1:0]  out_ret
);
  kind_e           kind;
  logic [PC_W-1:0] pc_p2, pc_p4, rel_tgt, abs_tgt;
  logic [PC_W-1:0] nxt_pc, nxt_ret;
  logic            nxt_push;

  assign kind = kind_e'(in_kind);

  npu_seq #(.PC_W(PC_W)) u_seq (
    .pc    (in_pc),
    .pc_p2 (pc_p2),
    .pc_p4 (pc_p4)
  );

  npu_rel #(.PC_W(PC_W), .OFF_W(OFF_W)) u_rel (
    .base (pc_p2),
    .off  (in_off),
    .tgt  (rel_tgt)
  );

  npu_abs #(.PC_W(PC_W), .ABS_W(ABS_W)) u_abs (
    .field (in_abs),
    .tgt   (abs_tgt)
  );

  always_comb begin
    nxt_pc   = pc_p2;
    nxt_push = 1'b0;
    nxt_ret  = '0;
    unique case (kind)
      K_SEQ32: nxt_pc = pc_p4;
      K_JMP:   nxt_pc = abs_tgt;
      K_BR:    nxt_pc = in_taken ? rel_tgt : pc_p2;
      K_CALL: begin
        nxt_pc   = abs_tgt;
        nxt_push = 1'b1;
        nxt_ret  = pc_p4;
      end
      K_RCALL: begin
        nxt_pc   = rel_tgt;
        nxt_push = 1'b1;
        nxt_ret  = pc_p2;
      end
      default: nxt_pc = pc_p2;
    endcase
  end

  npu_stage #(.PC_W(PC_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_pc     (nxt_pc),
    .in_push   (nxt_push),
    .in_ret    (nxt_ret),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pc    (out_pc),
    .out_push  (out_push),
    .out_ret   (out_ret)
  );

  // R5: long call pushes the address four bytes on
  p_call_ret_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_kind == K_CALL |=> out_push && out_ret == $past(in_pc) + PC_W'(4));

  // R6: relative call pushes the address two bytes on
  p_rcall_ret_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_kind == K_RCALL |=> out_push && out_ret == $past(in_pc) + PC_W'(2));

  // R7: only calls push
  p_no_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_kind != K_CALL && in_kind != K_RCALL |=> !out_push);

  // R2: long jump lands on an even byte address
  p_jmp_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_kind == K_JMP |=> out_pc[0] == 1'b0);

  // R4: untaken branch falls through
  p_br_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_kind == K_BR && !in_taken |=> out_pc == $past(in_pc) + PC_W'(2));
endmodule

// File: tb/next_pc_unit_tb.sv
`timescale 1ns/1ps
module next_pc_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [20:0] in_pc = '0;
  logic [2:0]  in_kind = '0;
  logic        in_taken = 1'b0;
  logic [19:0] in_abs = '0;
  logic [10:0] in_off = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [20:0] out_pc;
  logic        out_push;
  logic [20:0] out_ret;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  next_pc_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_pc(in_pc), .in_kind(in_kind), .in_taken(in_taken),
    .in_abs(in_abs), .in_off(in_off),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_pc(out_pc), .out_push(out_push), .out_ret(out_ret)
  );

  function automatic logic [20:0] rel_exp(input logic [20:0] pc, input logic [10:0] off);
    int signed s;
    s = (int'(off) >= 1024) ? int'(off) - 2048 : int'(off);
    return 21'((int'(pc) + 2 + 2 * s) & 32'h1FFFFF);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [20:0] act, input logic [20:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xact(input logic [2:0] k, input logic [20:0] pc, input bit tk,
                      input logic [19:0] ab, input logic [10:0] of,
                      input logic [20:0] e_pc, input bit e_push, input logic [20:0] e_ret,
                      input string tag);
    @(negedge clk);
    in_kind = k; in_pc = pc; in_taken = tk; in_abs = ab; in_off = of; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, {tag, " valid"}, 21'(out_valid), 21'd1);
    chk(out_pc == e_pc, {tag, " pc"}, out_pc, e_pc);
    chk(out_push == e_push, {tag, " push"}, 21'(out_push), 21'(e_push));
    if (e_push) chk(out_ret == e_ret, {tag, " ret"}, out_ret, e_ret);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%h expected=%h", 21'd0, 21'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [20:0] pcs [3];
    pcs[0] = 21'h000000; pcs[1] = 21'h1FFFFE; pcs[2] = 21'h0007F0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk(out_valid == 1'b0, "R11 valid", 21'(out_valid), 21'd0);
    chk(out_push == 1'b0, "R11 push", 21'(out_push), 21'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R11 ready", 21'(in_ready), 21'd1);

    // R1 sequential, wrap and reserved codes
    for (int i = 0; i < 21; i++) begin
      logic [20:0] p;
      p = 21'(1) << i;
      xact(3'd0, p, 1'b1, 20'hFFFFF, 11'h7FF, p + 21'd2, 1'b0, 21'd0, "R1 seq16");
      xact(3'd1, p, 1'b1, 20'hFFFFF, 11'h7FF, p + 21'd4, 1'b0, 21'd0, "R1 seq32");
      xact(3'd6, p, 1'b1, 20'h12345, 11'h3FF, p + 21'd2, 1'b0, 21'd0, "R1 rsv6");
      xact(3'd7, p, 1'b0, 20'h12345, 11'h400, p + 21'd2, 1'b0, 21'd0, "R1 rsv7");
    end
    xact(3'd0, 21'h1FFFFE, 1'b0, 20'd0, 11'd0, 21'h000000, 1'b0, 21'd0, "R1 wrap16");
    xact(3'd1, 21'h1FFFFC, 1'b0, 20'd0, 11'd0, 21'h000000, 1'b0, 21'd0, "R1 wrap32");

    // R2 / R5 / R6 absolute targets, walking bits; taken qualifier ignored
    for (int i = 0; i < 22; i++) begin
      logic [19:0] a;
      logic [20:0] p;
      a = (i < 20) ? (20'(1) << i) : ((i == 20) ? 20'hFFFFF : 20'h00000);
      p = 21'h0ABCD0 + 21'(i * 6);
      xact(3'd2, p, i[0], a, 11'h155, {a, 1'b0}, 1'b0, 21'd0, "R2 jmp");
      xact(3'd4, p, i[0], a, 11'h2AA, {a, 1'b0}, 1'b1, p + 21'd4, "R5 call");
    end
    xact(3'd4, 21'h1FFFFC, 1'b1, 20'h00010, 11'd0, 21'h000020, 1'b1, 21'h000000, "R5 ret wrap");

    // R3 taken branches over every offset, several bases incl. wrap
    for (int j = 0; j < 3; j++)
      for (int o = 0; o < 2048; o++)
        xact(3'd3, pcs[j], 1'b1, 20'h0F0F0, 11'(o), rel_exp(pcs[j], 11'(o)), 1'b0, 21'd0, "R3 branch");

    // R6 relative call over every offset, taken low to show it is ignored
    for (int o = 0; o < 2048; o++)
      xact(3'd5, 21'h000400, 1'b0, 20'hAAAAA, 11'(o), rel_exp(21'h000400, 11'(o)), 1'b1, 21'h000402, "R6 rcall");

    // R4 untaken branch
    for (int o = 0; o < 2048; o += 97)
      xact(3'd3, 21'h012340, 1'b0, 20'd0, 11'(o), 21'h012342, 1'b0, 21'd0, "R4 fall");

    // R8 self loop
    xact(3'd3, 21'h00F00E, 1'b1, 20'd0, 11'h7FF, 21'h00F00E, 1'b0, 21'd0, "R8 br self");
    xact(3'd5, 21'h1FFFFE, 1'b1, 20'd0, 11'h7FF, 21'h1FFFFE, 1'b1, 21'h000000, "R8 rcall self");

    // R9 drain with no new request
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 drain", 21'(out_valid), 21'd0);

    // R10 back-pressure with a second request waiting
    out_ready = 1'b0;
    xact(3'd4, 21'h000100, 1'b0, 20'h00800, 11'd0, 21'h001000, 1'b1, 21'h000104, "R10 first");
    @(negedge clk);
    in_kind = 3'd1; in_pc = 21'h000200; in_valid = 1'b1;
    #0.1;
    chk(in_ready == 1'b0, "R10 ready low", 21'(in_ready), 21'd0);
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b1, "R10 held valid", 21'(out_valid), 21'd1);
    chk(out_pc == 21'h001000, "R10 held pc", out_pc, 21'h001000);
    chk(out_push == 1'b1, "R10 held push", 21'(out_push), 21'd1);
    chk(out_ret == 21'h000104, "R10 held ret", out_ret, 21'h000104);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_pc == 21'h000204, "R10 second pc", out_pc, 21'h000204);
    chk(out_push == 1'b0, "R7 second push", 21'(out_push), 21'd0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 empty", 21'(out_valid), 21'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule